// File: doc/BRIEF.md
# PCI Configuration Port Decoder

This block sits on a host I/O bus and provides the two-port mechanism software uses to reach PCI configuration space. A 32-bit selector register holds an enable bit, a bus number, a device/function number and a dword register index. Four adjacent data ports form a byte-addressable window onto the configuration space of the selected device/function.

Cycles on the data window are turned into single-cycle read or write strobes on a configuration target interface. That interface carries the device/function number, the byte offset, the access length, the write data and a present flag. Only bus zero with the enable bit set is forwarded. Writes aimed at read-only header bytes are dropped. Device/functions that were never registered read back as all ones.

A registration port fills a presence table with one bit per device/function. It refuses an index that is already taken. A mirror register keeps the data value of the most recent data-window transfer.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the selector register reads 0, the data mirror is 0 and no device/function is marked present.
- R2: The selector register at I/O port 0x0CF8 is loaded only by a write with length 4; writes of length 1 or 2 to that port leave it unchanged.
- R3: A read of port 0x0CF8 with length 4 returns the selector; any other length returns 0x0000FFFF.
- R4: A data-window cycle (ports 0x0CFC..0x0CFF) is forwarded only when selector bit 31 is 1 and selector bits 23:16 are 0. Otherwise no target strobe is raised and a read returns 0xFFFFFFFF.
- R5: A forwarded cycle presents device/function = selector bits 15:8 and byte offset = {selector bits 7:2, 2'b00} + data port bits 1:0. A read returns the target's data in the same cycle.
- R6: A read of an unregistered device/function, or with a length greater than 4, returns 0xFFFFFFFF and raises no read strobe.
- R7: A forwarded write reaches the target only when the offset is 4..7, 12, 13 or above 14; writes to offsets 0..3, 8..11 and 14 raise no write strobe.
- R8: Every data-window read loads the mirror with the value returned on the bus.
- R9: A write that reaches the target loads the mirror with the write data shifted left by 8 times data port bits 1:0. Writes that are dropped leave the mirror unchanged.
- R10: A registration request is accepted (ok high in the same cycle) only if its index is free. An accepted index is present from the next cycle; a second request for it is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_valid_i | input | 1 | I/O cycle valid this clock |
| io_write_i | input | 1 | 1 = write, 0 = read |
| io_port_i | input | 16 | I/O port address |
| io_len_i | input | 3 | Access length in bytes (1, 2, 4; larger is unmapped) |
| io_wdata_i | input | 32 | Write data |
| io_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| reg_valid_i | input | 1 | Registration request |
| reg_devfn_i | input | 8 | Device/function to register |
| reg_ok_o | output | 1 | Registration accepted |
| tgt_rd_o | output | 1 | Configuration read strobe |
| tgt_wr_o | output | 1 | Configuration write strobe |
| tgt_devfn_o | output | 8 | Selected device/function |
| tgt_offset_o | output | 8 | Byte offset in configuration space |
| tgt_len_o | output | 3 | Access length |
| tgt_wdata_o | output | 32 | Write data to target |
| tgt_present_o | output | 1 | Selected device/function is registered |
| tgt_rdata_i | input | 32 | Read data from target |
| data_mirror_o | output | 32 | Data mirror register |

## Verification
The bench builds the block with its default parameters: 16-bit port addresses at the standard pair and a 256-entry presence table indexed by the full device/function byte. Because the table is full size, the bench can register one device/function and then select both it and a neighbour that differs only in the function bits. With the target model returning data that encodes the presented device/function and offset, a single read confirms both the field extraction and the presence lookup. The bench also sweeps the write-protection boundary offsets on both sides (0, 5, 11, 13, 14, 15).

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [31:0] FWD_MASK  = 32'h80FF_0000;
  localparam logic [31:0] FWD_MATCH = 32'h8000_0000;
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;
  localparam logic [31:0] SHORT_SEL = 32'h0000_FFFF;
  localparam logic [2:0]  LEN_DW    = 3'd4;

  // header bytes the target may be written at
  function automatic logic off_writable(input logic [7:0] off);
    return ((off >= 8'd4) && (off <= 8'd7)) || (off == 8'd12) ||
           (off == 8'd13) || (off > 8'd14);
  endfunction
endpackage

// File: rtl/cfg_sel_reg.sv
module cfg_sel_reg (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_o <= '0;
    else if (load_i) sel_o <= wdata_i;
  end

  // R2
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(sel_o));
endmodule

// File: rtl/cfg_presence.sv
module cfg_presence #(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned NUM  = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_valid_i,
  input  logic [IDX_W-1:0] reg_idx_i,
  output logic             reg_ok_o,
  input  logic [IDX_W-1:0] look_idx_i,
  output logic             look_hit_o
);
  logic [NUM-1:0] occ_q;

  assign reg_ok_o   = reg_valid_i && !occ_q[reg_idx_i];
  assign look_hit_o = occ_q[look_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       occ_q <= '0;
    else if (reg_ok_o) occ_q[reg_idx_i] <= 1'b1;
  end

  // R10
  reg_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_ok_o |=> occ_q[$past(reg_idx_i)]);
  // R10
  reg_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_valid_i |=> $stable(occ_q));
endmodule

// File: rtl/cfg_fwd_decode.sv
module cfg_fwd_decode
  import cfg_port_pkg::*;
(
  input  logic [31:0] sel_i,
  input  logic [1:0]  lane_i,
  input  logic [2:0]  len_i,
  input  logic        present_i,
  output logic        fwd_ok_o,
  output logic [7:0]  devfn_o,
  output logic [7:0]  offset_o,
  output logic        wr_allow_o
);
  logic unused_sel;
  assign unused_sel = ^sel_i[1:0];

  assign devfn_o    = sel_i[15:8];
  assign offset_o   = {sel_i[7:2], 2'b00} + {6'd0, lane_i};
  assign fwd_ok_o   = ((sel_i & FWD_MASK) == FWD_MATCH) && present_i && (len_i <= LEN_DW);
  assign wr_allow_o = fwd_ok_o && off_writable(offset_o);
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] SEL_PORT  = 16'h0CF8,
  parameter logic [15:0] DATA_BASE = 16'h0CFC,
  parameter int unsigned DEVFN_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               io_valid_i,
  input  logic               io_write_i,
  input  logic [15:0]        io_port_i,
  input  logic [2:0]         io_len_i,
  input  logic [31:0]        io_wdata_i,
  output logic [31:0]        io_rdata_o,
  input  logic               reg_valid_i,
  input  logic [DEVFN_W-1:0] reg_devfn_i,
  output logic               reg_ok_o,
  output logic               tgt_rd_o,
  output logic               tgt_wr_o,
  output logic [7:0]         tgt_devfn_o,
  output logic [7:0]         tgt_offset_o,
  output logic [2:0]         tgt_len_o,
  output logic [31:0]        tgt_wdata_o,
  output logic               tgt_present_o,
  input  logic [31:0]        tgt_rdata_i,
  output logic [31:0]        data_mirror_o
);
  logic [31:0] sel_q;
  logic        sel_hit, data_hit, sel_load;
  logic        fwd_ok, wr_allow;
  logic [1:0]  lane;

  assign lane     = io_port_i[1:0];
  assign sel_hit  = io_valid_i && (io_port_i == SEL_PORT);
  assign data_hit = io_valid_i && (io_port_i[15:2] == DATA_BASE[15:2]);
  assign sel_load = sel_hit && io_write_i && (io_len_i == LEN_DW);

  cfg_sel_reg u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sel_load),
    .wdata_i(io_wdata_i),
    .sel_o  (sel_q)
  );

  cfg_presence #(.IDX_W(DEVFN_W)) u_pres (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_valid_i(reg_valid_i),
    .reg_idx_i  (reg_devfn_i),
    .reg_ok_o   (reg_ok_o),
    .look_idx_i (tgt_devfn_o[DEVFN_W-1:0]),
    .look_hit_o (tgt_present_o)
  );

  cfg_fwd_decode u_dec (
    .sel_i     (sel_q),
    .lane_i    (lane),
    .len_i     (io_len_i),
    .present_i (tgt_present_o),
    .fwd_ok_o  (fwd_ok),
    .devfn_o   (tgt_devfn_o),
    .offset_o  (tgt_offset_o),
    .wr_allow_o(wr_allow)
  );

  assign tgt_rd_o    = data_hit && !io_write_i && fwd_ok;
  assign tgt_wr_o    = data_hit && io_write_i && wr_allow;
  assign tgt_len_o   = io_len_i;
  assign tgt_wdata_o = io_wdata_i;

  always_comb begin
    io_rdata_o = ALL_ONES;
    if (sel_hit)       io_rdata_o = (io_len_i == LEN_DW) ? sel_q : SHORT_SEL;
    else if (tgt_rd_o) io_rdata_o = tgt_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      data_mirror_o <= '0;
    else if (data_hit && !io_write_i) data_mirror_o <= io_rdata_o;
    else if (tgt_wr_o)                data_mirror_o <= io_wdata_i << {lane, 3'b000};
  end

  // R7
  wr_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_wr_o |-> !(tgt_offset_o <= 8'd3 || (tgt_offset_o >= 8'd8 && tgt_offset_o <= 8'd11)
                   || tgt_offset_o == 8'd14));
  // R6
  rd_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_rd_o || tgt_wr_o) |-> (tgt_present_o && tgt_len_o <= 3'd4));
  // R4
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tgt_rd_o, tgt_wr_o}));
  // R9
  mirror_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_write_i && !tgt_wr_o) |=> $stable(data_mirror_o));
endmodule

// File: tb/cfg_port_decoder_bench.sv
module cfg_port_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        io_valid = 0, io_write = 0;
  logic [15:0] io_port = 0;
  logic [2:0]  io_len = 0;
  logic [31:0] io_wdata = 0, io_rdata;
  logic        reg_valid = 0, reg_ok;
  logic [7:0]  reg_devfn = 0;
  logic        t_rd, t_wr, t_pres;
  logic [7:0]  t_devfn, t_off;
  logic [2:0]  t_len;
  logic [31:0] t_wdata, t_rdata, mirror;
  int checks = 0, errors = 0;

  // target model: echoes the presented selection
  assign t_rdata = {t_devfn, t_off, 16'hC0DE};

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_decoder u_cfg_port_decoder (
    .clk_i(clk), .rst_ni(rst_n),
    .io_valid_i(io_valid), .io_write_i(io_write), .io_port_i(io_port),
    .io_len_i(io_len), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .reg_valid_i(reg_valid), .reg_devfn_i(reg_devfn), .reg_ok_o(reg_ok),
    .tgt_rd_o(t_rd), .tgt_wr_o(t_wr), .tgt_devfn_o(t_devfn), .tgt_offset_o(t_off),
    .tgt_len_o(t_len), .tgt_wdata_o(t_wdata), .tgt_present_o(t_pres),
    .tgt_rdata_i(t_rdata), .data_mirror_o(mirror)
  );

  logic [31:0] c_rdata;
  logic        c_rd, c_wr;
  logic [7:0]  c_off, c_devfn;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one I/O cycle; captures combinational outputs mid-cycle
  task automatic io(input logic wr, input logic [15:0] port, input logic [2:0] len,
                    input logic [31:0] wd);
    @(negedge clk);
    io_valid = 1; io_write = wr; io_port = port; io_len = len; io_wdata = wd;
    #1;
    c_rdata = io_rdata; c_rd = t_rd; c_wr = t_wr; c_off = t_off; c_devfn = t_devfn;
    @(negedge clk);
    io_valid = 0; io_write = 0;
  endtask

  task automatic set_sel(input logic [31:0] v);
    io(1, 16'h0CF8, 3'd4, v);
  endtask

  task automatic t_reset;
    chk("R1 mirror", mirror, 0);
    io(0, 16'h0CF8, 3'd4, 0);
    chk("R1 sel", c_rdata, 0);
    chk("R1 present", {31'd0, t_pres}, 0);
  endtask

  task automatic t_register;
    @(negedge clk); reg_valid = 1; reg_devfn = 8'h08; #1;
    chk("R10 first ok", {31'd0, reg_ok}, 1);
    @(negedge clk); #1;
    chk("R10 second refused", {31'd0, reg_ok}, 0);
    reg_valid = 0;
  endtask

  task automatic t_sel;
    set_sel(32'h8000_0810);
    io(1, 16'h0CF8, 3'd2, 32'h1234_5678);
    io(0, 16'h0CF8, 3'd4, 0);
    chk("R2 narrow write ignored", c_rdata, 32'h8000_0810);
    io(0, 16'h0CF8, 3'd1, 0);
    chk("R3 narrow read", c_rdata, 32'h0000_FFFF);
  endtask

  task automatic t_read_fwd;
    io(0, 16'h0CFE, 3'd1, 0);
    chk("R5 devfn", {24'd0, c_devfn}, 32'h08);
    chk("R5 offset", {24'd0, c_off}, 32'h12);
    chk("R5 rdata", c_rdata, 32'h0812_C0DE);
    chk("R8 mirror read", mirror, 32'h0812_C0DE);
  endtask

  task automatic t_unmapped;
    set_sel(32'h8000_0910);
    io(0, 16'h0CFC, 3'd4, 0);
    chk("R6 absent", c_rdata, 32'hFFFF_FFFF);
    chk("R8 mirror ones", mirror, 32'hFFFF_FFFF);
    set_sel(32'h8001_0810);
    io(0, 16'h0CFC, 3'd4, 0);
    chk("R4 bus1 data", c_rdata, 32'hFFFF_FFFF);
    chk("R4 bus1 strobe", {31'd0, c_rd}, 0);
    set_sel(32'h0000_0810);
    io(0, 16'h0CFC, 3'd4, 0);
    chk("R4 disabled", c_rdata, 32'hFFFF_FFFF);
    set_sel(32'h8000_0810);
    io(0, 16'h0CFC, 3'd7, 0);
    chk("R6 long len", c_rdata, 32'hFFFF_FFFF);
    chk("R6 long strobe", {31'd0, c_rd}, 0);
  endtask

  task automatic wr_case(input logic [31:0] sel, input logic [15:0] port,
                         input logic [31:0] wd, input logic exp_wr, input logic [31:0] exp_m);
    set_sel(sel);
    io(1, port, 3'd1, wd);
    chk("R7 strobe", {31'd0, c_wr}, {31'd0, exp_wr});
    chk("R9 mirror", mirror, exp_m);
  endtask

  task automatic t_writes;
    wr_case(32'h8000_0804, 16'h0CFD, 32'h5A, 1, 32'h0000_5A00);  // off 5
    wr_case(32'h8000_0800, 16'h0CFC, 32'h11, 0, 32'h0000_5A00);  // off 0
    wr_case(32'h8000_0808, 16'h0CFF, 32'h22, 0, 32'h0000_5A00);  // off 11
    wr_case(32'h8000_080C, 16'h0CFE, 32'h33, 0, 32'h0000_5A00);  // off 14
    wr_case(32'h8000_080C, 16'h0CFD, 32'h44, 1, 32'h0000_4400);  // off 13
    wr_case(32'h8000_080C, 16'h0CFF, 32'h55, 1, 32'h5500_0000);  // off 15
    wr_case(32'h8000_0910, 16'h0CFC, 32'h66, 0, 32'h5500_0000);  // absent
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 3) rst_n = 1;
        @(negedge clk);
        t_reset; t_register; t_sel; t_read_fwd; t_unmapped; t_writes;
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule